// File: doc/BRIEF.md
# Floating-Point Special-Operand Resolver

This combinational block sits beside a single-precision floating-point arithmetic unit. It looks at the two 32-bit operands and the selected operation (add, subtract, multiply, divide or square root), sorts each operand into one of six classes, and decides whether the special values alone fix the answer. When they do, it raises `special` so that the surrounding unit takes `result` from this block instead of from its main datapath. In the same cycle it drives the invalid-operation and divide-by-zero exception flags.

Operands are taken as IEEE single-precision words: bit 31 is the sign, bits 30:23 the biased exponent and bits 22:0 the fraction. NaN outputs are always quiet. An input NaN passes its sign and its lower fraction bits through to the output, so diagnostic payloads survive the operation. For square root only `op_a` counts and `op_b` is ignored. Rounding, overflow, underflow and all arithmetic on ordinary finite operands belong to the main unit.

Top module: `fp_special_resolver`

## Requirements
- R1: Each operand is classified on `a_class`/`b_class` with the codes 0 zero (exponent 0, fraction 0), 1 subnormal (exponent 0, fraction nonzero), 2 normal (exponent 1..254), 3 infinity (exponent 255, fraction 0).
- R2: An operand with exponent 255 and a nonzero fraction is a NaN. It is coded 4 (quiet) when fraction bit 22 is 1 and 5 (signaling) when fraction bit 22 is 0.
- R3: If exactly one relevant operand is a NaN, `special` is 1 and `result` keeps that NaN's sign, its exponent of 255 and fraction bits 21:0, with fraction bit 22 forced to 1.
- R4: If both operands are NaNs and the operation is not square root, the result is built from `op_a` in the way R3 describes.
- R5: A signaling NaN in any relevant operand sets `flag_invalid`. A quiet NaN input with no signaling NaN beside it sets no flag.
- R6: 0/0, inf/inf, zero times infinity in either order, the addition of opposite-signed infinities, the subtraction of like-signed infinities and the square root of any value below zero (including -inf, excluding -0) return 0x7FC00000 with `flag_invalid` set.
- R7: A finite nonzero value divided by a zero returns an infinity whose sign is the XOR of the operand signs, with `flag_divzero` set.
- R8: For division, an infinity divided by a finite value returns infinity, a finite value divided by infinity returns zero, and a zero divided by a finite nonzero value returns zero. In each case the sign is the XOR of the operand signs and no flag is set.
- R9: For multiplication, an infinity times a nonzero value returns infinity and a zero times a finite value returns zero, each with the XOR sign and no flag.
- R10: For add and subtract, when a single infinity takes part, or two infinities with the same effective sign (the sign of `op_b` inverted for subtract), the result is that infinity with its effective sign and no flag.
- R11: Square root of +0 or -0 returns the operand unchanged and square root of +inf returns +inf, with no flag. For square root the value of `op_b` has no effect on `special`, `result` or the flags.
- R12: When no rule above applies, `special` is 0 and `result`, `flag_invalid` and `flag_divzero` are all 0. The two flags are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First (destination) operand |
| op_b | input | 32 | Second operand, unused for square root |
| op_sel | input | 3 | Operation: 0 add, 1 subtract, 2 multiply, 3 divide, 4 square root |
| a_class | output | 3 | Class code of `op_a` |
| b_class | output | 3 | Class code of `op_b` |
| special | output | 1 | Result is fixed by special values; use `result` |
| result | output | 32 | Special result, zero when `special` is 0 |
| flag_invalid | output | 1 | Invalid-operation exception |
| flag_divzero | output | 1 | Divide-by-zero exception |

## Verification
The assertions take for granted that `op_sel` only carries the five defined operation codes. Several of them tie the absence of `special` to both relevant operands being finite, and that link only holds for defined operations. The stimulus draws the operation from codes 0 to 4 alone. The operands are built deliberately from each of the six classes, with random signs and payloads, so that every pairing of classes appears under every operation and no class is left to chance.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int OP_W   = 3;
    localparam int CLS_W  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_DIV  = 3'd3,
        OP_SQRT = 3'd4
    } op_e;

    typedef enum logic [CLS_W-1:0] {
        CL_ZERO = 3'd0,
        CL_SUBN = 3'd1,
        CL_NORM = 3'd2,
        CL_INF  = 3'd3,
        CL_QNAN = 3'd4,
        CL_SNAN = 3'd5
    } cls_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        logic     hit;
        logic     invalid;
        logic     divzero;
        fp_word_t value;
    } verdict_t;

    function automatic logic cls_is_nan(cls_e c);
        return (c == CL_QNAN) || (c == CL_SNAN);
    endfunction

    function automatic logic cls_is_finite(cls_e c);
        return (c == CL_ZERO) || (c == CL_SUBN) || (c == CL_NORM);
    endfunction

    function automatic fp_word_t make_inf(logic s);
        fp_word_t w;
        w.sign = s;
        w.exp  = '1;
        w.frac = '0;
        return w;
    endfunction

    function automatic fp_word_t make_zero(logic s);
        fp_word_t w;
        w.sign = s;
        w.exp  = '0;
        w.frac = '0;
        return w;
    endfunction

    function automatic fp_word_t default_qnan();
        fp_word_t w;
        w.sign             = 1'b0;
        w.exp              = '1;
        w.frac             = '0;
        w.frac[FRAC_W-1]   = 1'b1;
        return w;
    endfunction

    function automatic fp_word_t quieten(fp_word_t w);
        fp_word_t q;
        q                = w;
        q.frac[FRAC_W-1] = 1'b1;
        return q;
    endfunction

endpackage

// File: rtl/fpsr_classify.sv
module fpsr_classify
    import fpsr_pkg::*;
(
    input  fp_word_t word,
    output cls_e     cls
);
    logic exp_full, exp_empty, frac_any, top_frac;

    always_comb begin
        exp_full  = &word.exp;
        exp_empty = ~|word.exp;
        frac_any  = |word.frac;
        top_frac  = word.frac[FRAC_W-1];
        if (exp_empty)
            cls = frac_any ? CL_SUBN : CL_ZERO;
        else if (!exp_full)
            cls = CL_NORM;
        else if (!frac_any)
            cls = CL_INF;
        else
            cls = top_frac ? CL_QNAN : CL_SNAN;
    end
endmodule

// File: rtl/fpsr_nan_pick.sv
module fpsr_nan_pick
    import fpsr_pkg::*;
(
    input  op_e      op,
    input  fp_word_t a,
    input  fp_word_t b,
    input  cls_e     a_cls,
    input  cls_e     b_cls,
    output verdict_t verdict
);
    logic use_b, a_nan, b_nan;

    always_comb begin
        use_b   = (op != OP_SQRT);
        a_nan   = cls_is_nan(a_cls);
        b_nan   = use_b && cls_is_nan(b_cls);
        verdict = '0;
        if (a_nan || b_nan) begin
            verdict.hit     = 1'b1;
            verdict.invalid = (a_cls == CL_SNAN) || (use_b && (b_cls == CL_SNAN));
            verdict.value   = a_nan ? quieten(a) : quieten(b);
        end
    end
endmodule

// File: rtl/fpsr_rules.sv
module fpsr_rules
    import fpsr_pkg::*;
(
    input  op_e      op,
    input  fp_word_t a,
    input  fp_word_t b,
    input  cls_e     a_cls,
    input  cls_e     b_cls,
    output verdict_t verdict
);
    logic a_inf, b_inf, a_zero, b_zero, xsign, b_eff;

    always_comb begin
        a_inf   = (a_cls == CL_INF);
        b_inf   = (b_cls == CL_INF);
        a_zero  = (a_cls == CL_ZERO);
        b_zero  = (b_cls == CL_ZERO);
        xsign   = a.sign ^ b.sign;
        b_eff   = (op == OP_SUB) ? ~b.sign : b.sign;
        verdict = '0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                if (a_inf && b_inf && (a.sign != b_eff)) begin
                    verdict.hit     = 1'b1;
                    verdict.invalid = 1'b1;
                    verdict.value   = default_qnan();
                end else if (a_inf) begin
                    verdict.hit   = 1'b1;
                    verdict.value = make_inf(a.sign);
                end else if (b_inf) begin
                    verdict.hit   = 1'b1;
                    verdict.value = make_inf(b_eff);
                end
            end
            OP_MUL: begin
                if ((a_inf && b_zero) || (a_zero && b_inf)) begin
                    verdict.hit     = 1'b1;
                    verdict.invalid = 1'b1;
                    verdict.value   = default_qnan();
                end else if (a_inf || b_inf) begin
                    verdict.hit   = 1'b1;
                    verdict.value = make_inf(xsign);
                end else if (a_zero || b_zero) begin
                    verdict.hit   = 1'b1;
                    verdict.value = make_zero(xsign);
                end
            end
            OP_DIV: begin
                if ((a_zero && b_zero) || (a_inf && b_inf)) begin
                    verdict.hit     = 1'b1;
                    verdict.invalid = 1'b1;
                    verdict.value   = default_qnan();
                end else if (b_zero && !a_inf) begin
                    verdict.hit     = 1'b1;
                    verdict.divzero = 1'b1;
                    verdict.value   = make_inf(xsign);
                end else if (a_inf) begin
                    verdict.hit   = 1'b1;
                    verdict.value = make_inf(xsign);
                end else if (b_inf || a_zero) begin
                    verdict.hit   = 1'b1;
                    verdict.value = make_zero(xsign);
                end
            end
            OP_SQRT: begin
                if (a_zero) begin
                    verdict.hit   = 1'b1;
                    verdict.value = a;
                end else if (a.sign) begin
                    verdict.hit     = 1'b1;
                    verdict.invalid = 1'b1;
                    verdict.value   = default_qnan();
                end else if (a_inf) begin
                    verdict.hit   = 1'b1;
                    verdict.value = make_inf(1'b0);
                end
            end
            default: verdict = '0;
        endcase
    end
endmodule

// File: rtl/fp_special_resolver.sv
module fp_special_resolver
    import fpsr_pkg::*;
(
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [OP_W-1:0]   op_sel,
    output logic [CLS_W-1:0]  a_class,
    output logic [CLS_W-1:0]  b_class,
    output logic              special,
    output logic [WORD_W-1:0] result,
    output logic              flag_invalid,
    output logic              flag_divzero
);
    fp_word_t wa, wb;
    cls_e     ca, cb;
    op_e      op;
    verdict_t v_nan, v_rule, v_out;

    assign wa = fp_word_t'(op_a);
    assign wb = fp_word_t'(op_b);
    assign op = op_e'(op_sel);

    fpsr_classify u_cls_a (.word(wa), .cls(ca));
    fpsr_classify u_cls_b (.word(wb), .cls(cb));

    fpsr_nan_pick u_nan (
        .op(op), .a(wa), .b(wb), .a_cls(ca), .b_cls(cb), .verdict(v_nan)
    );

    fpsr_rules u_rules (
        .op(op), .a(wa), .b(wb), .a_cls(ca), .b_cls(cb), .verdict(v_rule)
    );

    always_comb begin
        v_out        = v_nan.hit ? v_nan : v_rule;
        a_class      = ca;
        b_class      = cb;
        special      = v_out.hit;
        result       = v_out.hit ? WORD_W'(v_out.value) : '0;
        flag_invalid = v_out.hit && v_out.invalid;
        flag_divzero = v_out.hit && v_out.divzero;
    end

    always_comb begin
        a_r12_flags_exclusive: assert (!(flag_invalid && flag_divzero))
            else $error("invalid and divide-by-zero raised together");
        a_r12_idle_is_quiet: assert (special || (result == '0 && !flag_invalid && !flag_divzero))
            else $error("non-special output not cleared");
        a_r3_nan_out_quiet: assert (!v_nan.hit || (v_nan.value.exp == '1 && v_nan.value.frac[FRAC_W-1]))
            else $error("propagated NaN not quiet");
        a_r7_divzero_gives_inf: assert (!flag_divzero || (special && op == OP_DIV && cb == CL_ZERO
                                        && result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}))
            else $error("divide-by-zero without infinity");
        a_r6_invalid_qnan: assert (!flag_invalid || (special && result[WORD_W-2 -: EXP_W] == '1
                                   && result[FRAC_W-1]))
            else $error("invalid without quiet NaN");
        if (op_sel <= OP_W'(OP_SQRT)) begin
            a_r12_plain_needs_finite: assert (special || (cls_is_finite(ca)
                                              && (op == OP_SQRT || cls_is_finite(cb))))
                else $error("special dropped with non-finite operand");
        end
    end
endmodule

// File: tb/sim_fp_special_resolver.sv
module sim_fp_special_resolver;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0, op_b = '0;
    logic [2:0]  op_sel = '0;
    logic [2:0]  a_class, b_class;
    logic        special, flag_invalid, flag_divzero;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fp_special_resolver u0 (
        .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .a_class(a_class), .b_class(b_class), .special(special),
        .result(result), .flag_invalid(flag_invalid), .flag_divzero(flag_divzero)
    );

    localparam bit [31:0] QDEF = 32'h7FC00000;

    function automatic int kind(bit [31:0] w);
        int e = int'(w[30:23]);
        bit [22:0] f = w[22:0];
        if (e == 0) return (f == 0) ? 0 : 1;
        if (e != 255) return 2;
        if (f == 0) return 3;
        return f[22] ? 4 : 5;
    endfunction

    function automatic bit [31:0] inf_of(bit s);
        return {s, 8'hFF, 23'h0};
    endfunction

    task automatic model(input int op, input bit [31:0] a, input bit [31:0] b,
                         output bit sp, output bit [31:0] r, output bit inv,
                         output bit dz, output string tag);
        int  ka = kind(a);
        int  kb = (op == 4) ? 2 : kind(b);
        bit  sa = a[31];
        bit  sb = b[31];
        bit  sx = sa ^ sb;
        bit  fin_a = (ka < 3);
        bit  fin_b = (kb < 3);
        sp = 1; r = 0; inv = 0; dz = 0; tag = "R12";
        if (ka >= 4 || kb >= 4) begin
            inv = (ka == 5) || (kb == 5);
            if (ka >= 4) r = a | 32'h00400000;
            else         r = b | 32'h00400000;
            tag = (ka >= 4 && kb >= 4) ? "R4" : (inv ? "R5" : "R3");
            return;
        end
        if (op == 0 || op == 1) begin
            bit eb = (op == 1) ? !sb : sb;
            tag = "R10";
            if (ka == 3 && kb == 3 && sa != eb) begin r = QDEF; inv = 1; tag = "R6"; end
            else if (ka == 3) r = inf_of(sa);
            else if (kb == 3) r = inf_of(eb);
            else sp = 0;
        end else if (op == 2) begin
            tag = "R9";
            if ((ka == 3 && kb == 0) || (ka == 0 && kb == 3)) begin r = QDEF; inv = 1; tag = "R6"; end
            else if (ka == 3 || kb == 3) r = inf_of(sx);
            else if (ka == 0 || kb == 0) r = {sx, 31'h0};
            else sp = 0;
        end else if (op == 3) begin
            tag = "R8";
            if ((ka == 0 && kb == 0) || (ka == 3 && kb == 3)) begin r = QDEF; inv = 1; tag = "R6"; end
            else if (kb == 0 && fin_a) begin r = inf_of(sx); dz = 1; tag = "R7"; end
            else if (ka == 3) r = inf_of(sx);
            else if (kb == 3 || ka == 0) r = {sx, 31'h0};
            else sp = 0;
        end else begin
            tag = "R11";
            if (ka == 0) r = a;
            else if (sa) begin r = QDEF; inv = 1; tag = "R6"; end
            else if (ka == 3) r = inf_of(1'b0);
            else sp = 0;
        end
        if (!sp) tag = "R12";
        if (!fin_b && op != 4) begin end
    endtask

    task automatic apply(input int op, input bit [31:0] a, input bit [31:0] b);
        bit e_sp, e_inv, e_dz;
        bit [31:0] e_r;
        string tag;
        @(posedge clk);
        op_a = a; op_b = b; op_sel = 3'(op);
        @(negedge clk);
        model(op, a, b, e_sp, e_r, e_inv, e_dz, tag);
        checks++;
        if (int'(a_class) != kind(a) || int'(b_class) != kind(b)) begin
            errors++;
            $display("FAIL %s class a=%08h b=%08h: got %0d/%0d expected %0d/%0d",
                     (kind(a) >= 4 || kind(b) >= 4) ? "R2" : "R1", a, b,
                     a_class, b_class, kind(a), kind(b));
        end
        checks++;
        if (special != e_sp || result != e_r || flag_invalid != e_inv || flag_divzero != e_dz) begin
            errors++;
            $display("FAIL %s op=%0d a=%08h b=%08h: got sp=%0b r=%08h inv=%0b dz=%0b expected sp=%0b r=%08h inv=%0b dz=%0b",
                     tag, op, a, b, special, result, flag_invalid, flag_divzero,
                     e_sp, e_r, e_inv, e_dz);
        end
    endtask

    function automatic bit [31:0] pick(int k);
        bit s = 1'($urandom);
        bit [22:0] f = 23'($urandom);
        case (k)
            0: return {s, 31'h0};
            1: return {s, 8'h00, (f == 0) ? 23'h1 : f};
            2: return {s, 8'(1 + $urandom % 254), f};
            3: return {s, 8'hFF, 23'h0};
            4: return {s, 8'hFF, 1'b1, f[21:0]};
            default: return {s, 8'hFF, 1'b0, (f[21:0] == 0) ? 22'h1 : f[21:0]};
        endcase
    endfunction

    initial begin
        #500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (special || result != 0 || flag_invalid || flag_divzero || a_class != 0 || b_class != 0) begin
            errors++;
            $display("FAIL R12 idle state: got sp=%0b r=%08h expected sp=0 r=00000000", special, result);
        end
        // R1 R2 classification of each kind
        apply(0, 32'h00000001, 32'h3F800000);
        apply(0, 32'h80000000, 32'h7F800001);
        apply(0, 32'h7FC00000, 32'h3E800000);
        // R7 divide by zero, both signs
        apply(3, 32'h40A00000, 32'h00000000);
        apply(3, 32'hBF800000, 32'h00000000);
        apply(3, 32'h3F800000, 32'h80000000);
        // R6 invalid cases
        apply(3, 32'h00000000, 32'h80000000);
        apply(3, 32'h7F800000, 32'hFF800000);
        apply(2, 32'h00000000, 32'h7F800000);
        apply(2, 32'hFF800000, 32'h80000000);
        apply(0, 32'h7F800000, 32'hFF800000);
        apply(1, 32'hFF800000, 32'hFF800000);
        apply(4, 32'hBF800000, 32'h0);
        apply(4, 32'hFF800000, 32'h0);
        // R8 division results without flags
        apply(3, 32'hFF800000, 32'h40000000);
        apply(3, 32'h40000000, 32'hFF800000);
        apply(3, 32'h80000000, 32'h40400000);
        apply(3, 32'h7F800000, 32'h00000000);
        // R9 R10 infinities
        apply(2, 32'h7F800000, 32'h80000001);
        apply(1, 32'h3F800000, 32'h7F800000);
        apply(0, 32'h7F800000, 32'h7F800000);
        // R11 square root and ignored b
        apply(4, 32'h80000000, 32'h7F800001);
        apply(4, 32'h7F800000, 32'hFFC00000);
        apply(4, 32'h3F800000, 32'h7F800005);
        // R3 R4 R5 NaN handling
        apply(0, 32'hFF812345, 32'h3F800000);
        apply(2, 32'h3F800000, 32'h7FC0ABCD);
        apply(3, 32'h7F800007, 32'hFFC00009);
        apply(1, 32'hFFC00003, 32'h7F800002);
        // R12 ordinary finite operands
        apply(2, 32'h3F800000, 32'h00400000);
        for (int i = 0; i < 3000; i++)
            apply($urandom % 5, pick($urandom % 6), pick($urandom % 6));
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule